// File: doc/BRIEF.md
# Ring Cycle Phase Calculator

This block turns a per-period count of ring-oscillator rising edges into a small signed sample, one per reference clock cycle. Its behaviour is that of an unbounded cycle counter from which an integer modulus M is taken away for every reference period that elapses. The difference, called the residue, is saturated to the five values -2 to +2. When the surrounding loop is locked the residue never reaches the limits and the long-run mean of the samples follows the negated fractional frequency word. Saturation occurs only while the loop is acquiring.

The edge count reaches the block already carried into the reference clock domain, one value per reference cycle. The modulus is written through a configuration write strobe. A write applies from the next reference period onward, so no period is ever split between two modulus values. A clip pulse and a sticky clip flag show when saturation took place. Software clears the sticky flag with a clear strobe.

Top module: `ring_phase_calc`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `y_out` to 0 and `clip_pulse` and `clip_seen` to 0, and loads the modulus with its default of 64.
- R2: At every rising edge with `rst_n` high, `y_out` takes the value y_prev + `edge_cnt` - M, saturated to the range [-2, 2]. Here y_prev is the value `y_out` held before that edge and M is the modulus held before that edge.
- R3: `y_out` is a 3-bit two's-complement value and never leaves the range -2 to +2.
- R4: `clip_pulse` is high for exactly the cycle after an edge whose update in R2 had to be saturated, and the `y_out` shown in that cycle is then +2 or -2.
- R5: `clip_seen` is set at the same edge that raises `clip_pulse`. It then holds until an edge where `clip_clr` is high and no new clip occurs; if a clip and a clear coincide, the flag stays set.
- R6: A `m_wr` edge whose `m_wdata` lies in the range 40 to 80 inclusive loads that value as M. The count presented at that same edge still uses the old M, and the new M applies from the next edge onward.
- R7: A `m_wr` whose `m_wdata` lies below 40 or above 80 leaves M unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one edge per reference period |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_cnt | input | 8 | Oscillator rising edges counted in the current period |
| m_wr | input | 1 | Modulus write strobe |
| m_wdata | input | 7 | Modulus value to write |
| clip_clr | input | 1 | Clear strobe for the sticky clip flag |
| y_out | output | 3 | Signed five-level sample |
| clip_pulse | output | 1 | The last update was saturated |
| clip_seen | output | 1 | Sticky record of any saturation |

## Verification
The sample `y_out` and its `clip_pulse` come from the count presented at the edge before. `clip_seen` changes at that same edge. A modulus write acts on the count of the following cycle, not the count written alongside it. The bench drives every input on the falling clock edge and compares all three outputs at the next falling edge, after exactly one rising edge, against a reference model that applies these latencies. Directed steps cover the two saturation limits, a coincident clip and clear, modulus writes at both range limits and just outside them, and a write placed in the same cycle as a count. A seeded random run with counts near M and occasional writes and clears follows.

// File: rtl/ring_phase_pkg.sv
// Shared sample type and limits for the ring phase calculator.
// Assumes the five-level alphabet -2..+2, which fits in 3 bits.
package ring_phase_pkg;
    localparam int Y_W   = 3;
    localparam int Y_LIM = 2;
    typedef logic signed [Y_W-1:0] ysamp_t;
endpackage

// File: rtl/rpc_modulus_reg.sv
// Modulus register: accepts a write only when the value lies in
// [M_MIN, M_MAX]. The residue update uses the value held before the edge,
// so a write counts from the next reference period.
// Assumes M_RST lies inside the legal range.
module rpc_modulus_reg #(
    parameter int M_W   = 7,
    parameter int M_MIN = 40,
    parameter int M_MAX = 80,
    parameter int M_RST = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [M_W-1:0] wdata_i,
    output logic [M_W-1:0] m_o
);
    localparam logic [M_W-1:0] LO = M_W'(M_MIN);
    localparam logic [M_W-1:0] HI = M_W'(M_MAX);
    localparam logic [M_W-1:0] RV = M_W'(M_RST);

    logic legal;

    // Range test on the incoming write value.
    always_comb legal = (wdata_i >= LO) && (wdata_i <= HI);

    // Hold M; take a write only when it is legal.
    always_ff @(posedge clk) begin
        if (!rst_n)             m_o <= RV;
        else if (wr_i && legal) m_o <= wdata_i;
    end

    // R7
    m_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(m_o) >= M_MIN) && (int'(m_o) <= M_MAX));

    // R6
    m_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && int'(wdata_i) >= M_MIN && int'(wdata_i) <= M_MAX)
        |=> (m_o == $past(wdata_i)));

    // R7
    m_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (int'(wdata_i) < M_MIN || int'(wdata_i) > M_MAX))
        |=> $stable(m_o));
endmodule

// File: rtl/rpc_residue.sv
// Residue accumulator: adds this period's edge count, subtracts M and
// saturates to the five-level alphabet. The saturated value is the state.
// Assumes edge_cnt and M are unsigned and are sampled at the period edge.
module rpc_residue
    import ring_phase_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int M_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [M_W-1:0]   m_i,
    output ysamp_t           y_o,
    output logic             clip_o,
    output logic             clip_now_o
);
    localparam int SUM_W = ((CNT_W > M_W) ? CNT_W : M_W) + 3;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(Y_LIM);
    localparam logic signed [SUM_W-1:0] LO = -HI;

    logic signed [SUM_W-1:0] cnt_ext, m_ext, y_ext, sum;
    ysamp_t                  nxt;

    // Extend the operands to a width that cannot overflow.
    always_comb begin
        cnt_ext = {{(SUM_W-CNT_W){1'b0}}, cnt_i};
        m_ext   = {{(SUM_W-M_W){1'b0}}, m_i};
        y_ext   = {{(SUM_W-Y_W){y_o[Y_W-1]}}, y_o};
        sum     = y_ext + cnt_ext - m_ext;
    end

    // Saturate the raw sum and flag when a limit was applied.
    always_comb begin
        if (sum > HI) begin
            nxt        = ysamp_t'(Y_LIM);
            clip_now_o = 1'b1;
        end else if (sum < LO) begin
            nxt        = ysamp_t'(-Y_LIM);
            clip_now_o = 1'b1;
        end else begin
            nxt        = sum[Y_W-1:0];
            clip_now_o = 1'b0;
        end
    end

    // Register the residue and the clip pulse once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o    <= '0;
            clip_o <= 1'b0;
        end else begin
            y_o    <= nxt;
            clip_o <= clip_now_o;
        end
    end

    // R3
    y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_o >= ysamp_t'(-Y_LIM)) && (y_o <= ysamp_t'(Y_LIM)));

    // R4
    clip_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clip_o |-> (y_o == ysamp_t'(Y_LIM) || y_o == ysamp_t'(-Y_LIM)));
endmodule

// File: rtl/rpc_sticky_flag.sv
// Sticky clip flag: set by any saturation, cleared by a strobe. A set and
// a clear at the same edge leave it set, so no event is lost.
module rpc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/ring_phase_calc.sv
// Ring cycle phase calculator top. Turns per-period oscillator edge counts
// into a saturated five-level residue against n*M.
// Assumes edge_cnt is already synchronous to clk, one value per period.
module ring_phase_calc #(
    parameter int CNT_W = 8,
    parameter int M_W   = 7,
    parameter int M_MIN = 40,
    parameter int M_MAX = 80,
    parameter int M_RST = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   edge_cnt,
    input  logic               m_wr,
    input  logic [M_W-1:0]     m_wdata,
    input  logic               clip_clr,
    output logic signed [2:0]  y_out,
    output logic               clip_pulse,
    output logic               clip_seen
);
    import ring_phase_pkg::*;

    logic [M_W-1:0] m_cur;
    logic           clip_now;
    ysamp_t         y_int;

    rpc_modulus_reg #(
        .M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX), .M_RST(M_RST)
    ) u_mod (
        .clk(clk), .rst_n(rst_n), .wr_i(m_wr), .wdata_i(m_wdata), .m_o(m_cur)
    );

    rpc_residue #(.CNT_W(CNT_W), .M_W(M_W)) u_res (
        .clk(clk), .rst_n(rst_n), .cnt_i(edge_cnt), .m_i(m_cur),
        .y_o(y_int), .clip_o(clip_pulse), .clip_now_o(clip_now)
    );

    rpc_sticky_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(clip_now), .clr_i(clip_clr),
        .flag_o(clip_seen)
    );

    // Present the internal sample on the output port.
    always_comb y_out = y_int;

    // R5
    seen_follows_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clip_pulse |-> clip_seen);
endmodule

// File: tb/sim_ring_phase_calc.sv
module sim_ring_phase_calc;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        edge_cnt = '0;
    logic              m_wr = 1'b0;
    logic [6:0]        m_wdata = '0;
    logic              clip_clr = 1'b0;
    logic signed [2:0] y_out;
    logic              clip_pulse, clip_seen;

    int checks = 0, errors = 0;
    int exp_y = 0, exp_m = 64;
    bit exp_clip = 0, exp_seen = 0, done = 0;

    always #10 clk = ~clk;

    ring_phase_calc u0 (.clk(clk), .rst_n(rst_n), .edge_cnt(edge_cnt),
        .m_wr(m_wr), .m_wdata(m_wdata), .clip_clr(clip_clr),
        .y_out(y_out), .clip_pulse(clip_pulse), .clip_seen(clip_seen));

    function automatic int sat5(int v);
        if (v > 2)  return 2;
        if (v < -2) return -2;
        return v;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "y_out", int'(y_out), exp_y);
        chk(tag, "clip_pulse", int'(clip_pulse), int'(exp_clip));
        chk(tag, "clip_seen", int'(clip_seen), int'(exp_seen));
        checks++;
        if (int'(y_out) > 2 || int'(y_out) < -2) begin
            errors++;
            $display("FAIL R3 y_out range actual=%0d expected=-2..2", int'(y_out));
        end
    endtask

    // Drive on the falling edge, cross one rising edge, compare at the next fall.
    task automatic step(string tag, int cnt, bit wr, int wv, bit clr);
        int raw;
        edge_cnt = 8'(cnt); m_wr = wr; m_wdata = 7'(wv); clip_clr = clr;
        raw      = exp_y + cnt - exp_m;
        exp_y    = sat5(raw);
        exp_clip = (raw != exp_y);
        exp_seen = exp_clip || (exp_seen && !clr);
        if (wr && wv >= 40 && wv <= 80) exp_m = wv;
        @(negedge clk);
        compare(tag);
        m_wr = 1'b0; clip_clr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20150225));
        repeat (3) @(negedge clk);
        compare("R1");                       // reset state held
        rst_n = 1'b1;
        step("R1", 64, 0, 0, 0);             // default M=64: count 64 leaves 0
        step("R2", 65, 0, 0, 0);             // +1
        step("R2", 65, 0, 0, 0);             // +2
        step("R4", 65, 0, 0, 0);             // would be 3, clips at 2
        step("R5", 64, 0, 0, 0);             // sticky holds, no clip
        step("R5", 64, 0, 0, 1);             // clear without clip
        step("R2", 60, 0, 0, 0);             // 2-4 = -2
        step("R4", 0, 0, 0, 0);              // deep negative, clip -2
        step("R5", 255, 0, 0, 1);            // clip high together with clear
        step("R6", 64, 1, 40, 0);            // write 40, this count uses old M
        step("R6", 40, 0, 0, 0);             // new M=40 applies
        step("R7", 41, 1, 39, 0);            // below range, ignored
        step("R7", 38, 1, 81, 0);            // above range, ignored
        step("R7", 40, 0, 0, 0);             // M still 40
        step("R6", 40, 1, 80, 0);            // upper limit accepted
        step("R6", 80, 0, 0, 0);
        step("R2", 79, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            int c;
            bit w, cl;
            int wv;
            c  = exp_m + int'($urandom_range(6)) - 3;
            if ($urandom_range(15) == 0) c = int'($urandom_range(255));
            w  = ($urandom_range(31) == 0);
            wv = 30 + int'($urandom_range(60));
            cl = ($urandom_range(7) == 0);
            step("R2", c, w, wv, cl);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule